// File: doc/BRIEF.md
# Power Rail Sequencing Supervisor

This block brings up a chain of supplies in a fixed order and then watches over them. It receives four single-bit rail-good flags from external comparators. Flag 0 belongs to the main input rail, and flags 1 to 3 belong to rails produced by regulators that this block switches on. The block drives three regulator enables and one combined power-good output. It moves through five states. Each step forward needs its qualifying set of flags to stay high for a set number of clock cycles. The main rail and the final all-rails check use a long qualification time. The two intermediate steps use a short one.

Once power-good is reached, fault handling becomes asymmetric. If the main rail drops, even for a single clock, every output turns off and the sequence starts again from the beginning. If a downstream rail stays low for the short qualification time, only power-good is withdrawn. The enables stay on, and power-good returns after a new long qualification of all four rails. Every flag passes through a synchronizer before the state machine sees it. Both qualification lengths are parameters given in clock cycles.

Top module: `pwr_seq_top`

## Requirements
- R1: The outputs follow the state in thermometer order. `reg_en_o[0]` is the first regulator enable, `reg_en_o[2]` is the third, and `pwr_good_o` is the last. The five states give {pwr_good_o, reg_en_o[2:0]} values of 0000, 0001, 0011, 0111 and 1111. No other combination ever appears.
- R2: From the idle state, `reg_en_o[0]` rises only after synchronized `rail_ok_i[0]` has been high for LONG_CYC consecutive cycles. Any low cycle restarts the count.
- R3: With only the first enable on, the second enable rises after `rail_ok_i[1:0]` have both been high for SHORT_CYC consecutive cycles.
- R4: With two enables on, the third enable rises after `rail_ok_i[2:0]` have all been high for SHORT_CYC consecutive cycles.
- R5: With three enables on, `pwr_good_o` rises after all four flags have been high for LONG_CYC consecutive cycles.
- R6: In any state other than idle, one low clock cycle on `rail_ok_i[0]` turns every output off. This happens within SYNC_STAGES+1 cycles of the input falling, and the sequence restarts from idle.
- R7: In the power-good state, if any of `rail_ok_i[3:1]` is low for SHORT_CYC consecutive cycles, `pwr_good_o` drops and all three enables stay high.
- R8: After power-good has been withdrawn by a downstream fault, it returns only after a fresh LONG_CYC run of all four flags high.
- R9: In the sequencing states, a low level on `rail_ok_i[3:1]` causes no state change. It only restarts the qualification count that is in progress.
- R10: While the synchronous active-high `rst` is high, all outputs are low and the flag inputs are ignored. After release, the block starts from idle.
- R11: In the power-good state, a downstream dip shorter than SHORT_CYC cycles leaves `pwr_good_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_ok_i | input | 4 | Rail-good flags; bit 0 is the main rail |
| reg_en_o | output | 3 | Regulator enables, bit 0 switched on first |
| pwr_good_o | output | 1 | Combined power-good |

## Verification
The bench builds the block with LONG_CYC = 40 and SHORT_CYC = 6, keeping SYNC_STAGES at 2. With these values a complete bring-up, a downstream-fault recovery and several restarts all fit in a few hundred cycles. Short values also let one-cycle glitches and sub-threshold dips be placed exactly, on either side of each qualification boundary. A behavioural model in the bench tracks the expected state and counter and is compared with the outputs on every cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_ONE   = 3'd1,
        SEQ_TWO   = 3'd2,
        SEQ_THREE = 3'd3,
        SEQ_GOOD  = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d;
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    assign pipe_d[0] = din;

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign pipe_d[g] = pipe_q[g-1];
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_qual.sv
module pwr_seq_qual #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] limit_m1,
    output logic          hit
);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        hit   = run && (cnt_q == limit_m1);
        cnt_d = cnt_q + 1'b1;
        if (!run || hit) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt_q <= limit_m1); // R9

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0); // R9

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
    parameter int LONG_CYC    = 19_000_000,
    parameter int SHORT_CYC   = 3_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rail_ok_i,
    output logic [2:0] reg_en_o,
    output logic       pwr_good_o
);
    import pwr_seq_pkg::*;

    localparam int N_RAIL = 4;
    localparam int CW     = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_SAT = CW'(LONG_CYC);

    logic [N_RAIL-1:0] rail_s;
    logic              run;
    logic              hit;
    logic [CW-1:0]     limit_m1;
    seq_regs_t         r_d;
    seq_regs_t         r_q;

    pwr_seq_sync #(.WIDTH(N_RAIL), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rail_ok_i),
        .dout (rail_s)
    );

    pwr_seq_qual #(.CW(CW)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .limit_m1 (limit_m1),
        .hit      (hit)
    );

    always_comb begin
        r_d      = r_q;
        run      = 1'b0;
        limit_m1 = SHORT_M1;
        unique case (r_q.st)
            SEQ_IDLE: begin
                run      = rail_s[0];
                limit_m1 = LONG_M1;
                if (hit) r_d.st = SEQ_ONE;
            end
            SEQ_ONE: begin
                run = &rail_s[1:0];
                if (!rail_s[0]) r_d.st = SEQ_IDLE;
                else if (hit)   r_d.st = SEQ_TWO;
            end
            SEQ_TWO: begin
                run = &rail_s[2:0];
                if (!rail_s[0]) r_d.st = SEQ_IDLE;
                else if (hit)   r_d.st = SEQ_THREE;
            end
            SEQ_THREE: begin
                run      = &rail_s;
                limit_m1 = LONG_M1;
                if (!rail_s[0]) r_d.st = SEQ_IDLE;
                else if (hit)   r_d.st = SEQ_GOOD;
            end
            SEQ_GOOD: begin
                run = rail_s[0] && !(&rail_s[3:1]);
                if (!rail_s[0]) r_d.st = SEQ_IDLE;
                else if (hit)   r_d.st = SEQ_THREE;
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: SEQ_IDLE};
        else     r_q <= r_d;
    end

    always_comb begin
        reg_en_o   = 3'b000;
        pwr_good_o = 1'b0;
        unique case (r_q.st)
            SEQ_ONE:   reg_en_o = 3'b001;
            SEQ_TWO:   reg_en_o = 3'b011;
            SEQ_THREE: reg_en_o = 3'b111;
            SEQ_GOOD:  begin reg_en_o = 3'b111; pwr_good_o = 1'b1; end
            default:   reg_en_o = 3'b000;
        endcase
    end

    // Run-length trackers used only by the assertions below
    logic [CW-1:0] main_run_d, main_run_q;
    logic [CW-1:0] all_run_d,  all_run_q;

    always_comb begin
        main_run_d = '0;
        all_run_d  = '0;
        if (rail_s[0])
            main_run_d = (main_run_q == LONG_SAT) ? main_run_q : main_run_q + 1'b1;
        if (&rail_s)
            all_run_d  = (all_run_q == LONG_SAT) ? all_run_q : all_run_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_run_q <= '0;
            all_run_q  <= '0;
        end else begin
            main_run_q <= main_run_d;
            all_run_q  <= all_run_d;
        end
    end

    AST_THERMO_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!reg_en_o[1] || reg_en_o[0]) && (!reg_en_o[2] || reg_en_o[1]) && (!pwr_good_o || reg_en_o[2])); // R1

    AST_EN1_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_en_o[0]) |-> main_run_q >= LONG_SAT); // R2

    AST_PG_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good_o) |-> all_run_q >= LONG_SAT); // R5

    AST_MAIN_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
        (!rail_s[0] && reg_en_o[0]) |=> (reg_en_o == 3'b000 && !pwr_good_o)); // R6

    AST_EN_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_en_o[0]) |-> (!$past(rail_s[0]) || $past(rst))); // R9

    AST_PG_DROP_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwr_good_o) && $past(rail_s[0]) && !$past(rst)) |-> reg_en_o == 3'b111); // R7

endmodule

// File: tb/pwr_seq_top_tb.sv
module pwr_seq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LONG_T     = 40;
    localparam int SHORT_T    = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rail = 4'b0000;
    logic [2:0] reg_en;
    logic       pwr_good;

    int    n_vec  = 0;
    int    n_bad  = 0;
    bit    cmp_on = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R10";

    pwr_seq_top #(.LONG_CYC(LONG_T), .SHORT_CYC(SHORT_T), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .rail_ok_i  (rail),
        .reg_en_o   (reg_en),
        .pwr_good_o (pwr_good)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: 0 idle .. 4 power-good
    int         m_st  = 0;
    int         m_cnt = 0;
    logic [3:0] m_s1  = 4'b0;
    logic [3:0] m_s2  = 4'b0;
    logic [3:0] m_s;
    bit         m_cond;
    int         m_lim;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_s1 = 4'b0; m_s2 = 4'b0;
        end else begin
            m_s = m_s2;
            if (m_st != 0 && !m_s[0]) begin
                m_st = 0; m_cnt = 0;
            end else begin
                case (m_st)
                    0:       begin m_cond = m_s[0];            m_lim = LONG_T;  end
                    1:       begin m_cond = m_s[0] && m_s[1];  m_lim = SHORT_T; end
                    2:       begin m_cond = m_s[0] && m_s[1] && m_s[2]; m_lim = SHORT_T; end
                    3:       begin m_cond = (m_s == 4'b1111);  m_lim = LONG_T;  end
                    default: begin m_cond = !(m_s[1] && m_s[2] && m_s[3]); m_lim = SHORT_T; end
                endcase
                if (!m_cond) m_cnt = 0;
                else begin
                    m_cnt++;
                    if (m_cnt == m_lim) begin
                        m_st  = (m_st == 4) ? 3 : m_st + 1;
                        m_cnt = 0;
                    end
                end
            end
            m_s2 = m_s1;
            m_s1 = rail;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            logic [3:0] exp_v;
            exp_v = {m_st == 4, m_st >= 3, m_st >= 2, m_st >= 1};
            n_vec++;
            if ({pwr_good, reg_en} !== exp_v) begin
                n_bad++;
                $display("FAIL %s t=%0t {pg,en}=%b expected %b", cur_req, $time, {pwr_good, reg_en}, exp_v);
            end
            // R1: only thermometer codes may appear
            n_vec++;
            if (!({pwr_good, reg_en} inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111})) begin
                n_bad++;
                $display("FAIL R1 t=%0t {pg,en}=%b expected a thermometer code", $time, {pwr_good, reg_en});
            end
        end
    end

    task automatic hold(input logic [3:0] v, input int n);
        rail = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        rail = 4'b1111;                // R10: flags ignored while in reset
        @(negedge clk);
        cmp_on = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        cur_req = "R2";
        hold(4'b0001, 20);
        hold(4'b0000, 1);              // restarts the long count
        hold(4'b0001, 50);

        cur_req = "R9";
        hold(4'b1101, 12);             // rail 1 missing: stay with one enable
        hold(4'b0011, 3);
        hold(4'b0001, 1);
        cur_req = "R3";
        hold(4'b0011, 15);
        cur_req = "R4";
        hold(4'b0111, 15);
        cur_req = "R5";
        hold(4'b1111, 30);
        hold(4'b1011, 1);              // restarts the long count
        hold(4'b1111, 60);

        cur_req = "R11";
        hold(4'b1011, 3);
        hold(4'b1111, 10);
        cur_req = "R7";
        hold(4'b0111, 12);
        cur_req = "R8";
        hold(4'b1111, 60);

        cur_req = "R6";
        hold(4'b1110, 1);              // one-cycle main-rail glitch
        hold(4'b1111, 70);
        hold(4'b1110, 1);
        hold(4'b1111, 5);

        cur_req = "R10";
        hold(4'b0011, 55);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        hold(4'b0011, 5);

        cur_req = "R1";
        hold(4'b1111, 120);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule